// File: doc/BRIEF.md
# Multicast Address Filter Table

This block keeps a small table of 48-bit group (multicast) addresses and decides, for each received frame, whether its destination address is one the station wants. The table cannot be written directly. Software first places a candidate address into two staging words on a 32-bit host register bus. It then writes a command word that picks one table slot and says whether to load that slot from the staging words or to copy the slot back into them. A separate mode word holds a promiscuous bit. When that bit is set, every frame is accepted. When it is clear, the comparison against the table decides.

The receive side presents one destination address with a valid strobe. One cycle later the block returns a valid flag and a hit flag. Host reads also return their data one cycle after the read strobe. The reset value of the promiscuous bit is set by a configuration input that is sampled while reset is held.

Top module: `mcf_filter_table`

## Requirements
- R1: After reset both staging words, the slot select and the read-not-write flag read as zero, and every table slot holds zero.
- R2: During reset the promiscuous bit takes the inverse of `cfg_filter_default`: it resets to 1 when the input is 0 and to 0 when the input is 1.
- R3: Offset 0x388 is a 32-bit read/write staging word that holds address bits [31:0].
- R4: At offset 0x38C, bits [15:0] hold address bits [47:32], bits [17:16] select the slot (00 to 11 give slots 0 to 3), and bit 23 is the read-not-write flag. All three fields read back as written. Bits [22:18] and [31:24] read as zero and ignore writes.
- R5: A write to 0x38C with bit 23 at 0 loads the selected slot with {written bits [15:0], current 0x388 value}.
- R6: A write to 0x38C with bit 23 at 1 copies slot bits [31:0] into 0x388 and slot bits [47:32] into 0x38C bits [15:0]. The address bits carried by that write are discarded, and the table does not change.
- R7: At offset 0x390, bit 31 is the promiscuous bit and is read/write. Bits [30:0] read as zero.
- R8: With the promiscuous bit at 0, `hit` is 1 only when the presented address equals some slot and its group bit `da_addr[0]` is 1.
- R9: With the promiscuous bit at 1, `hit` is 1 for every presented address.
- R10: `host_rdata` carries the addressed register in the cycle after `host_rd_en` and is zero in every other cycle. Unmapped offsets read as zero.
- R11: `hit_valid` is 1 exactly in the cycle after `da_valid`, and `hit` is 0 whenever `hit_valid` is 0. The decision uses the table and mode as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_filter_default | input | 1 | Selects the reset value of the promiscuous bit |
| host_wr_en | input | 1 | One-cycle host write strobe |
| host_rd_en | input | 1 | One-cycle host read strobe |
| host_addr | input | 12 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| da_valid | input | 1 | Destination address presented |
| da_addr | input | 48 | Destination address, group bit at bit 0 |
| hit_valid | output | 1 | Filter decision valid |
| hit | output | 1 | Frame accepted |

## Verification
The bench loads a slot that matches a test address exactly but has its group bit clear. A filter that ignored bit 0 would accept that unicast address. It issues a readback command that carries non-zero address bits, which would corrupt the staged upper half if the write data were not discarded. It also writes all-ones into the reserved fields of the command and mode words, where a design that stored them would return them on read. Finally it resets a second time with the opposite configuration level and checks that the promiscuous default flips and the old table contents no longer match.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
   localparam int unsigned HOST_AW = 12;
   localparam int unsigned HOST_DW = 32;
   localparam int unsigned MAC_W   = 48;

   localparam logic [11:0] OFS_STAGE_LO = 12'h388;
   localparam logic [11:0] OFS_STAGE_HI = 12'h38C;
   localparam logic [11:0] OFS_MODE     = 12'h390;

   localparam int unsigned SEL_LSB   = 16;
   localparam int unsigned RNW_POS   = 23;
   localparam int unsigned PROM_POS  = 31;
   localparam int unsigned GROUP_POS = 0;
endpackage

// File: rtl/mcf_host_regs.sv
module mcf_host_regs
   import mcf_pkg::*;
#(
   parameter int unsigned ADDR_W = HOST_AW,
   parameter int unsigned DATA_W = HOST_DW,
   parameter int unsigned ADR_W  = MAC_W,
   parameter int unsigned SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_filter_default,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              tbl_we,
   output logic [SEL_W-1:0]  tbl_sel,
   output logic [ADR_W-1:0]  tbl_wdata,
   input  logic [ADR_W-1:0]  tbl_rdata,
   output logic              promisc
);
   localparam int unsigned HI_W = ADR_W - DATA_W;
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_STAGE_LO);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_STAGE_HI);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

   logic [DATA_W-1:0] stage_lo_q;
   logic [HI_W-1:0]   stage_hi_q;
   logic [SEL_W-1:0]  sel_q;
   logic              rnw_q;
   logic              promisc_q;
   logic [DATA_W-1:0] rd_mux;
   logic              wr_lo, wr_hi, wr_mode, cmd_rnw;

   assign wr_lo   = wr_en && (addr == A_LO);
   assign wr_hi   = wr_en && (addr == A_HI);
   assign wr_mode = wr_en && (addr == A_MODE);
   assign cmd_rnw = wdata[RNW_POS];

   assign tbl_sel   = wdata[SEL_LSB +: SEL_W];
   assign tbl_we    = wr_hi && !cmd_rnw;
   assign tbl_wdata = {wdata[HI_W-1:0], stage_lo_q};
   assign promisc   = promisc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_lo_q <= '0;
         stage_hi_q <= '0;
         sel_q      <= '0;
         rnw_q      <= 1'b0;
         promisc_q  <= !cfg_filter_default;
      end else begin
         if (wr_lo) begin
            stage_lo_q <= wdata;
         end
         if (wr_hi) begin
            sel_q <= wdata[SEL_LSB +: SEL_W];
            rnw_q <= cmd_rnw;
            if (cmd_rnw) begin
               stage_lo_q <= tbl_rdata[DATA_W-1:0];
               stage_hi_q <= tbl_rdata[ADR_W-1:DATA_W];
            end else begin
               stage_hi_q <= wdata[HI_W-1:0];
            end
         end
         if (wr_mode) begin
            promisc_q <= wdata[PROM_POS];
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      if (addr == A_LO) begin
         rd_mux = stage_lo_q;
      end else if (addr == A_HI) begin
         rd_mux[HI_W-1:0]          = stage_hi_q;
         rd_mux[SEL_LSB +: SEL_W]  = sel_q;
         rd_mux[RNW_POS]           = rnw_q;
      end else if (addr == A_MODE) begin
         rd_mux[PROM_POS] = promisc_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         rdata <= rd_en ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/mcf_entry_table.sv
module mcf_entry_table #(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned ADR_W       = 48,
   parameter int unsigned SEL_W       = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [SEL_W-1:0]             sel,
   input  logic [ADR_W-1:0]             wdata,
   output logic [ADR_W-1:0]             rdata,
   output logic [NUM_ENTRIES*ADR_W-1:0] entries
);
   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      logic [ADR_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (we && (sel == SEL_W'(g))) begin
            slot_q <= wdata;
         end
      end
      assign entries[g*ADR_W +: ADR_W] = slot_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (sel == SEL_W'(i)) begin
            rdata = entries[i*ADR_W +: ADR_W];
         end
      end
   end
endmodule

// File: rtl/mcf_match.sv
module mcf_match
   import mcf_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned ADR_W       = 48,
   parameter bit          REG_HIT     = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_ENTRIES*ADR_W-1:0] entries,
   input  logic                         promisc,
   input  logic                         da_valid,
   input  logic [ADR_W-1:0]             da_addr,
   output logic                         hit_valid,
   output logic                         hit
);
   logic [NUM_ENTRIES-1:0] slot_eq;
   logic                   accept;

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
      assign slot_eq[g] = (entries[g*ADR_W +: ADR_W] == da_addr);
   end

   assign accept = da_valid && (promisc || (da_addr[GROUP_POS] && (|slot_eq)));

   if (REG_HIT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hit_valid <= 1'b0;
            hit       <= 1'b0;
         end else begin
            hit_valid <= da_valid;
            hit       <= accept;
         end
      end
   end else begin : g_comb
      assign hit_valid = da_valid;
      assign hit       = accept;
   end
endmodule

// File: rtl/mcf_filter_table.sv
module mcf_filter_table
   import mcf_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned ADDR_W      = HOST_AW,
   parameter int unsigned DATA_W      = HOST_DW,
   parameter int unsigned ADR_W       = MAC_W,
   parameter bit          REG_HIT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_filter_default,
   input  logic              host_wr_en,
   input  logic              host_rd_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              da_valid,
   input  logic [ADR_W-1:0]  da_addr,
   output logic              hit_valid,
   output logic              hit
);
   localparam int unsigned SEL_W = $clog2(NUM_ENTRIES);

   if (DATA_W != 32) begin : g_bad_dw
      $error("mcf_filter_table: DATA_W must be 32");
   end
   if (ADR_W <= DATA_W || ADR_W - DATA_W > SEL_LSB) begin : g_bad_aw
      $error("mcf_filter_table: upper address part must fit below the select field");
   end
   if (NUM_ENTRIES < 2 || SEL_W > RNW_POS - SEL_LSB) begin : g_bad_n
      $error("mcf_filter_table: NUM_ENTRIES out of range");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("mcf_filter_table: ADDR_W too narrow for register offsets");
   end

   logic                         tbl_we;
   logic [SEL_W-1:0]             tbl_sel;
   logic [ADR_W-1:0]             tbl_wdata;
   logic [ADR_W-1:0]             tbl_rdata;
   logic [NUM_ENTRIES*ADR_W-1:0] entries;
   logic                         promisc;

   mcf_host_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADR_W(ADR_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_filter_default(cfg_filter_default),
      .wr_en(host_wr_en), .rd_en(host_rd_en), .addr(host_addr),
      .wdata(host_wdata), .rdata(host_rdata),
      .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata),
      .tbl_rdata(tbl_rdata), .promisc(promisc)
   );

   mcf_entry_table #(
      .NUM_ENTRIES(NUM_ENTRIES), .ADR_W(ADR_W), .SEL_W(SEL_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .sel(tbl_sel),
      .wdata(tbl_wdata), .rdata(tbl_rdata), .entries(entries)
   );

   mcf_match #(
      .NUM_ENTRIES(NUM_ENTRIES), .ADR_W(ADR_W), .REG_HIT(REG_HIT)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .entries(entries), .promisc(promisc),
      .da_valid(da_valid), .da_addr(da_addr),
      .hit_valid(hit_valid), .hit(hit)
   );
endmodule

// File: rtl/mcf_filter_checker.sv
module mcf_filter_checker #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADR_W  = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_rd_en,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_rdata,
   input logic              da_valid,
   input logic [ADR_W-1:0]  da_addr,
   input logic              promisc,
   input logic              hit_valid,
   input logic              hit
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> hit_valid);  // R11
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> !hit_valid);  // R11
   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_valid |-> !hit);  // R11
   AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && promisc) |=> hit);  // R9
   AST_UNICAST_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !promisc && !da_addr[0]) |=> !hit);  // R8
   AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd_en |=> (host_rdata == '0));  // R10
   AST_CMD_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && host_addr == ADDR_W'(12'h38C)) |=>
      (host_rdata[31:24] == 8'h00 && host_rdata[22:18] == 5'h00));  // R4
   AST_MODE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && host_addr == ADDR_W'(12'h390)) |=>
      (host_rdata[30:0] == 31'h0));  // R7
endmodule

bind mcf_filter_table mcf_filter_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADR_W(ADR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_rd_en(host_rd_en), .host_addr(host_addr),
   .host_rdata(host_rdata), .da_valid(da_valid), .da_addr(da_addr),
   .promisc(promisc), .hit_valid(hit_valid), .hit(hit)
);

// File: tb/mcf_filter_table_test.sv
module mcf_filter_table_test;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_filter_default = 1'b0;
   logic        host_wr_en = 1'b0;
   logic        host_rd_en = 1'b0;
   logic [11:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        da_valid = 1'b0;
   logic [47:0] da_addr = '0;
   logic        hit_valid;
   logic        hit;

   int checks = 0;
   int errors = 0;
   bit live = 1'b0;
   bit done = 1'b0;

   mcf_filter_table uut (
      .clk(clk), .rst_n(rst_n), .cfg_filter_default(cfg_filter_default),
      .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .da_valid(da_valid), .da_addr(da_addr),
      .hit_valid(hit_valid), .hit(hit)
   );

   always #(PERIOD/2) clk = ~clk;

   // behavioural reference model
   logic [47:0] m_slot [4];
   logic [31:0] m_lo;
   logic [15:0] m_hi;
   logic [1:0]  m_sel;
   logic        m_rnw;
   logic        m_prom;
   logic [31:0] e_rdata;
   logic        e_hv, e_hit;

   function automatic logic [31:0] m_read(input logic [11:0] a);
      case (a)
         12'h388: return m_lo;
         12'h38C: return {8'h00, m_rnw, 5'h00, m_sel, m_hi};
         12'h390: return {m_prom, 31'h0};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_slot[i]) m_slot[i] = '0;
         m_lo = '0; m_hi = '0; m_sel = '0; m_rnw = 1'b0;
         m_prom = !cfg_filter_default;
         e_rdata = '0; e_hv = 1'b0; e_hit = 1'b0;
      end else begin
         bit any;
         any = 1'b0;
         foreach (m_slot[i]) if (m_slot[i] == da_addr) any = 1'b1;
         e_hv  = da_valid;
         e_hit = da_valid && (m_prom || (da_addr[0] && any));
         e_rdata = host_rd_en ? m_read(host_addr) : 32'h0;
         if (host_wr_en) begin
            case (host_addr)
               12'h388: m_lo = host_wdata;
               12'h38C: begin
                  m_sel = host_wdata[17:16];
                  m_rnw = host_wdata[23];
                  if (host_wdata[23]) begin
                     m_lo = m_slot[m_sel][31:0];
                     m_hi = m_slot[m_sel][47:32];
                  end else begin
                     m_hi = host_wdata[15:0];
                     m_slot[m_sel] = {m_hi, m_lo};
                  end
               end
               12'h390: m_prom = host_wdata[31];
               default: ;
            endcase
         end
      end
      live = 1'b1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (live && !done) begin
         chk("R10 model rdata", 64'(host_rdata), 64'(e_rdata));
         chk("R8 model hit", 64'(hit), 64'(e_hit));
         chk("R11 model hit_valid", 64'(hit_valid), 64'(e_hv));
      end
   end

   task automatic do_reset(input logic cfg);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_filter_default = cfg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr_en = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      host_rd_en = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd_en = 1'b0;
      d = host_rdata;
   endtask

   task automatic present(input logic [47:0] a, output logic h, output logic hv);
      @(negedge clk);
      da_valid = 1'b1; da_addr = a;
      @(negedge clk);
      da_valid = 1'b0;
      h = hit; hv = hit_valid;
   endtask

   function automatic logic [31:0] cmd(input logic rnw, input logic [1:0] s, input logic [15:0] hi);
      return {8'h00, rnw, 5'h00, s, hi};
   endfunction

   initial begin
      logic [31:0] d;
      logic h, hv;
      logic [47:0] ent [4];
      ent[0] = 48'h5E00_0000_0101;
      ent[1] = 48'hA1B2_C3D4_E5F7;
      ent[2] = 48'h1234_5678_9ABC;  // group bit clear
      ent[3] = 48'hFFFF_FFFF_FFFF;

      do_reset(1'b0);
      rd(12'h388, d); chk("R1 stage lo reset", 64'(d), 64'h0);
      rd(12'h38C, d); chk("R1 command word reset", 64'(d), 64'h0);
      rd(12'h390, d); chk("R2 promisc resets to 1 when cfg=0", 64'(d), 64'h8000_0000);
      present(48'h0000_0000_0002, h, hv);
      chk("R9 promisc accepts unicast", 64'(h), 64'h1);
      chk("R11 valid after strobe", 64'(hv), 64'h1);

      wr(12'h390, 32'h7FFF_FFFF);
      rd(12'h390, d); chk("R7 mode reserved bits read zero", 64'(d), 64'h0);
      wr(12'h388, 32'h1357_9BDF);
      rd(12'h388, d); chk("R3 stage lo read/write", 64'(d), 64'h1357_9BDF);
      wr(12'h38C, 32'hFF7D_BEEF);
      rd(12'h38C, d); chk("R4 reserved bits masked", 64'(d), 64'h0001_BEEF);

      for (int i = 0; i < 4; i++) begin
         wr(12'h388, ent[i][31:0]);
         wr(12'h38C, cmd(1'b0, 2'(i), ent[i][47:32]));
      end

      wr(12'h388, 32'hDEAD_BEEF);
      wr(12'h38C, cmd(1'b1, 2'd1, 16'h0F0F));
      rd(12'h388, d); chk("R6 readback lo slot1", 64'(d), 64'hC3D4_E5F7);
      rd(12'h38C, d); chk("R6 readback hi slot1, write data discarded", 64'(d), 64'h0081_A1B2);
      wr(12'h38C, cmd(1'b1, 2'd3, 16'h0000));
      rd(12'h38C, d); chk("R5 slot3 loaded", 64'(d), 64'h0083_FFFF);
      rd(12'h388, d); chk("R5 slot3 lo loaded", 64'(d), 64'hFFFF_FFFF);
      wr(12'h38C, cmd(1'b1, 2'd1, 16'h0000));
      rd(12'h388, d); chk("R6 readback leaves slot1 intact", 64'(d), 64'hC3D4_E5F7);

      present(ent[0], h, hv); chk("R8 slot0 match", 64'(h), 64'h1);
      present(ent[1], h, hv); chk("R8 slot1 match", 64'(h), 64'h1);
      present(ent[3], h, hv); chk("R8 slot3 match", 64'(h), 64'h1);
      present(ent[2], h, hv); chk("R8 equal but group bit clear", 64'(h), 64'h0);
      present(48'hA1B2_C3D4_E5F5, h, hv); chk("R8 near miss", 64'(h), 64'h0);
      chk("R11 valid on reject", 64'(hv), 64'h1);
      @(negedge clk);
      chk("R11 idle no valid", 64'(hit_valid), 64'h0);

      @(negedge clk); da_valid = 1'b1; da_addr = ent[1];
      @(negedge clk); da_addr = 48'h0000_0000_0011;
      chk("R8 back-to-back first", 64'(hit), 64'h1);
      @(negedge clk); da_valid = 1'b0;
      chk("R8 back-to-back second", 64'(hit), 64'h0);

      rd(12'h100, d); chk("R10 unmapped reads zero", 64'(d), 64'h0);
      @(negedge clk);
      chk("R10 idle rdata zero", 64'(host_rdata), 64'h0);

      wr(12'h390, 32'h8000_0000);
      present(48'h0000_0000_0010, h, hv); chk("R9 promisc accepts unmatched", 64'(h), 64'h1);

      do_reset(1'b1);
      rd(12'h390, d); chk("R2 promisc resets to 0 when cfg=1", 64'(d), 64'h0);
      wr(12'h38C, cmd(1'b1, 2'd0, 16'h0000));
      rd(12'h388, d); chk("R1 slot0 cleared lo", 64'(d), 64'h0);
      rd(12'h38C, d); chk("R1 slot0 cleared hi", 64'(d), 64'h0080_0000);
      present(ent[1], h, hv); chk("R1 old entry no longer matches", 64'(h), 64'h0);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R11 watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule